// File: doc/BRIEF.md
# Serial Slot Clock Mask Controller

This block decides which of ten copies of the secondary clock may run. When reset is released it reads a 16-bit mask frame from an external chain of two 8-bit parallel-in/serial-out shift registers. It drives three signals for that chain: a shift clock at a quarter of the system clock rate, a load/shift select line, and a serial mask input that it samples. The frame holds four pairs of active-low card-present bits, one pair per slot. It also holds five per-device mask bits and one bit for the clock that feeds back to the bridge's own secondary clock input.

The decoded mask goes into ten registered clock-enable outputs. All ten are updated in the same cycle. Each enable gates one copy of the system clock through a latch-based cell, so that a change of enable never produces a runt pulse. All clocks run from reset until the first frame is complete. A start request runs the fetch again. The enables then keep their previous values until the new frame is applied.

Top module: `slot_clk_mask_ctrl`

## Requirements
- R1: After reset, `clk_en` is all ones, `busy` is high, `done` is low and `sr_load` is high, and a fetch starts without any request.
- R2: During a fetch, `sr_load` is high for exactly one shift-clock period, which holds one rising edge of `sr_clk`. Fifteen further rising edges then follow with `sr_load` low, so there are 16 rising edges per fetch. Each `sr_clk` pulse is high for 2 system cycles and low for 2.
- R3: The frame is captured LSB first. The k-th sample of `mask_sdi` lands in frame bit k, for k = 0..15. Bit 0 is sampled on the system edge that raises the first shift clock after the load.
- R4: For each slot n = 0..3, `clk_en[n]` is 1 unless frame bits 2n and 2n+1 are both 1.
- R5: For each device i = 0..4, `clk_en[4+i]` is the inverse of frame bit 8+i.
- R6: `clk_en[9]` is the inverse of frame bit 13. Frame bits 14 and 15 have no effect on any output.
- R7: `clk_en` does not change during a fetch. It takes its new value, all bits at once, on the cycle after `done`.
- R8: `done` is a one-cycle pulse, and `busy` is high from the accepted start through the `done` cycle. `done` is visible after the 69th rising edge, counting the edge that samples `start` as the first.
- R9: A `start` that arrives while a fetch is in progress, other than in the `done` cycle, has no effect on the length or result of that fetch.
- R10: A `start` that arrives in the `done` cycle still applies the finished mask. A new fetch then begins at once, and `busy` stays high.
- R11: Each `gclk[k]` is low whenever `clk` is low. While `clk` is high, `gclk[k]` equals `clk_en[k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the clock being gated |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to run the mask fetch again |
| mask_sdi | input | 1 | Serial mask data from the shift-register chain |
| sr_clk | output | 1 | Shift clock to the external chain (clk/4) |
| sr_load | output | 1 | High selects parallel load, low selects shift |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle pulse when the new mask is applied |
| clk_en | output | 10 | Registered clock enables, one per output clock |
| gclk | output | 10 | Gated clock outputs |

## Verification
The interesting overlap is a new start request landing in the same cycle that a finished frame is applied. The mask transfer and the restart of the sequencer then happen on one edge. The bench watches for `done` at a falling edge and raises `start` right away, so the following rising edge sees both events. It also changes the external frame at that moment. It then checks three things: the enables hold the first frame's decode during the second fetch, `busy` never drops, and the second frame appears after exactly 69 edges.

// File: rtl/slot_mask_pkg.sv
package slot_mask_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_APPLY = 2'd3
    } fetch_state_e;

    // shift clock is clk divided by four: phase counter width
    localparam int PH_W = 2;
    localparam logic [PH_W-1:0] PH_RISE = 2'd1;   // edge that raises sr_clk
    localparam logic [PH_W-1:0] PH_HIGH = 2'd2;
    localparam logic [PH_W-1:0] PH_LAST = 2'd3;

endpackage

// File: rtl/mask_fetch_seq.sv
module mask_fetch_seq
    import slot_mask_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int CNT_W   = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             sr_clk,
    output logic             sr_load,
    output logic             sample,
    output logic [CNT_W-1:0] bit_idx,
    output logic             apply,
    output logic             busy
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        fetch_state_e    st;
        logic [PH_W-1:0] ph;
        logic [CNT_W-1:0] cnt;
        logic            sclk;
        logic            sload;
    } seq_t;

    seq_t q, d;
    logic last_bit;
    logic pulse_ok;

    always_comb begin
        d        = q;
        sample   = 1'b0;
        apply    = 1'b0;
        last_bit = (q.cnt == LAST_BIT);
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st = ST_LOAD;
                    d.ph = '0;
                end
            end
            ST_LOAD: begin
                d.ph = q.ph + 1'b1;
                if (q.ph == PH_LAST) begin
                    d.st  = ST_SHIFT;
                    d.cnt = '0;
                end
            end
            ST_SHIFT: begin
                d.ph = q.ph + 1'b1;
                if (q.ph == PH_RISE) sample = 1'b1;
                if (q.ph == PH_LAST) begin
                    if (last_bit) d.st  = ST_APPLY;
                    else          d.cnt = q.cnt + 1'b1;
                end
            end
            ST_APPLY: begin
                apply = 1'b1;
                d.ph  = '0;
                d.st  = start ? ST_LOAD : ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
        // the last sample needs no further shift
        pulse_ok = (q.st == ST_LOAD) || ((q.st == ST_SHIFT) && !last_bit);
        d.sclk   = pulse_ok && ((q.ph == PH_RISE) || (q.ph == PH_HIGH));
        d.sload  = (d.st == ST_LOAD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_LOAD;
            q.ph    <= '0;
            q.cnt   <= '0;
            q.sclk  <= 1'b0;
            q.sload <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sr_clk  = q.sclk;
    assign sr_load = q.sload;
    assign bit_idx = q.cnt;
    assign busy    = (q.st != ST_IDLE);

endmodule

// File: rtl/mask_capture.sv
module mask_capture #(
    parameter int CNT_W  = 4,
    parameter int USED_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [CNT_W-1:0]  bit_idx,
    input  logic              sdi,
    output logic [USED_W-1:0] frame
);

    localparam logic [CNT_W:0] USED_L = (CNT_W + 1)'(USED_W);

    typedef struct packed {
        logic [USED_W-1:0] bits;
    } cap_t;

    cap_t q, d;

    always_comb begin
        d = q;
        // bits past the used range are clocked in but dropped
        if (sample && ({1'b0, bit_idx} < USED_L)) begin
            d.bits[bit_idx] = sdi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign frame = q.bits;

endmodule

// File: rtl/mask_decode.sv
module mask_decode #(
    parameter int N_SLOTS = 4,
    parameter int N_DEVS  = 5,
    parameter int USED_W  = 2*N_SLOTS + N_DEVS + 1,
    parameter int N_OUT   = N_SLOTS + N_DEVS + 1
) (
    input  logic [USED_W-1:0] frame,
    output logic [N_OUT-1:0]  en
);

    localparam int DEV_BASE = 2*N_SLOTS;
    localparam int FB_BIT   = DEV_BASE + N_DEVS;

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        // a card is present when either active-low presence bit is low
        assign en[s] = ~(frame[2*s] & frame[2*s+1]);
    end

    for (genvar i = 0; i < N_DEVS; i++) begin : g_dev
        assign en[N_SLOTS+i] = ~frame[DEV_BASE+i];
    end

    assign en[N_OUT-1] = ~frame[FB_BIT];

endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
    input  logic clk_src,
    input  logic en,
    output logic gclk
);

    logic en_l;

    // enable passes only while the source clock is low
    always_latch begin
        if (!clk_src) en_l = en;
    end

    assign gclk = clk_src & en_l;

endmodule

// File: rtl/slot_clk_mask_ctrl.sv
module slot_clk_mask_ctrl #(
    parameter int N_SLOTS = 4,
    parameter int N_DEVS  = 5,
    parameter int FRAME_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      mask_sdi,
    output logic                      sr_clk,
    output logic                      sr_load,
    output logic                      busy,
    output logic                      done,
    output logic [N_SLOTS+N_DEVS:0]   clk_en,
    output logic [N_SLOTS+N_DEVS:0]   gclk
);

    localparam int N_OUT  = N_SLOTS + N_DEVS + 1;
    localparam int USED_W = 2*N_SLOTS + N_DEVS + 1;
    localparam int CNT_W  = $clog2(FRAME_W);

    logic             sample;
    logic             apply;
    logic [CNT_W-1:0] bit_idx;
    logic [USED_W-1:0] frame;
    logic [N_OUT-1:0] dec_en;

    mask_fetch_seq #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .sr_clk  (sr_clk),
        .sr_load (sr_load),
        .sample  (sample),
        .bit_idx (bit_idx),
        .apply   (apply),
        .busy    (busy)
    );

    mask_capture #(.CNT_W(CNT_W), .USED_W(USED_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample),
        .bit_idx (bit_idx),
        .sdi     (mask_sdi),
        .frame   (frame)
    );

    mask_decode #(.N_SLOTS(N_SLOTS), .N_DEVS(N_DEVS), .USED_W(USED_W), .N_OUT(N_OUT)) u_dec (
        .frame (frame),
        .en    (dec_en)
    );

    typedef struct packed {
        logic [N_OUT-1:0] en;
    } en_t;

    en_t q, d;

    always_comb begin
        d = q;
        if (apply) d.en = dec_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.en <= '1;
        else        q    <= d;
    end

    assign clk_en = q.en;
    assign done   = apply;

    for (genvar k = 0; k < N_OUT; k++) begin : g_gate
        clk_gate_cell u_gate (
            .clk_src (clk),
            .en      (q.en[k]),
            .gclk    (gclk[k])
        );
    end

endmodule

// File: rtl/slot_clk_mask_chk.sv
module slot_clk_mask_chk #(
    parameter int N_OUT = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             sr_clk,
    input logic             sr_load,
    input logic [N_OUT-1:0] clk_en,
    input logic [N_OUT-1:0] gclk
);

    logic seen_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    seen_done <= 1'b0;
        else if (done) seen_done <= 1'b1;
    end

    assert_reset_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_done |-> (&clk_en));

    assert_load_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sr_load |-> busy);

    assert_sclk_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_clk) |=> sr_clk);

    assert_sclk_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_clk && $past(sr_clk)) |=> !sr_clk);

    assert_en_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(clk_en));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_gclk_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        gclk == '0);

endmodule

bind slot_clk_mask_ctrl slot_clk_mask_chk #(.N_OUT(N_SLOTS + N_DEVS + 1)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .sr_clk  (sr_clk),
    .sr_load (sr_load),
    .clk_en  (clk_en),
    .gclk    (gclk)
);

// File: tb/slot_clk_mask_ctrl_test.sv
module slot_clk_mask_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mask_sdi;
    logic       sr_clk, sr_load, busy, done;
    logic [9:0] clk_en, gclk;

    int n_chk = 0;
    int n_bad = 0;

    // external shift-register chain model
    logic [15:0] pat_ext = 16'hFFFF;
    logic [4:0]  idx = 5'd0;
    int          rises = 0;
    int          loads = 0;

    always #2 clk = ~clk;

    always @(posedge sr_clk) begin
        rises <= rises + 1;
        if (sr_load) begin
            idx   <= 5'd0;
            loads <= loads + 1;
        end else begin
            idx <= idx + 5'd1;
        end
    end

    assign mask_sdi = (idx < 5'd16) ? pat_ext[idx[3:0]] : 1'b0;

    slot_clk_mask_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mask_sdi (mask_sdi),
        .sr_clk   (sr_clk),
        .sr_load  (sr_load),
        .busy     (busy),
        .done     (done),
        .clk_en   (clk_en),
        .gclk     (gclk)
    );

    function automatic logic [9:0] exp_en(input logic [15:0] p);
        logic [9:0] e;
        for (int s = 0; s < 4; s++) e[s] = ~(p[2*s] & p[2*s+1]);
        for (int i = 0; i < 5; i++) e[4+i] = ~p[8+i];
        e[9] = ~p[13];
        return e;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // waits from the negedge after start for done; returns edge count
    task automatic wait_done(input logic [9:0] hold, input int poke, output int cyc,
                             output logic held, output logic busy_ok);
        cyc = 1; held = 1'b1; busy_ok = 1'b1;
        while (!done && cyc < 300) begin
            if (clk_en != hold) held = 1'b0;
            if (!busy) busy_ok = 1'b0;
            if (cyc == poke) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        if (clk_en != hold) held = 1'b0;
    endtask

    task automatic run_and_check(input logic [15:0] p, input int poke);
        int   cyc;
        logic held, bok;
        logic [9:0] prev;
        prev = clk_en;
        @(negedge clk);
        pat_ext = p;
        rises = 0; loads = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(prev, poke, cyc, held, bok);
        chk(cyc == 69, poke > 0 ? "R9 fetch length" : "R8 fetch length", cyc, 69);
        chk(held, "R7 enables held during fetch", clk_en, prev);
        chk(bok, "R8 busy during fetch", bok, 1);
        @(negedge clk);
        chk(clk_en == exp_en(p), "R3/R4/R5/R6 decoded enables", clk_en, exp_en(p));
        chk(!done && !busy, "R8 done single pulse, idle after", {done, busy}, 0);
        chk(rises == 16 && loads == 1, "R2 shift clock rises and loads", rises * 16 + loads, 16 * 16 + 1);
        @(posedge clk);
        #1;
        chk(gclk == clk_en, "R11 gated clock high phase", gclk, clk_en);
        @(negedge clk);
        chk(gclk == 10'h000, "R11 gated clock low phase", gclk, 0);
    endtask

    initial begin
        #(4 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int   cyc;
        logic held, bok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(clk_en == 10'h3FF, "R1 reset enables", clk_en, 10'h3FF);
        chk(busy && !done && sr_load, "R1 reset status", {busy, done, sr_load}, 3'b101);

        // automatic fetch after reset, frame all ones
        wait_done(10'h3FF, 0, cyc, held, bok);
        chk(held, "R1 enables on until first frame", clk_en, 10'h3FF);
        @(negedge clk);
        chk(clk_en == 10'h000, "R1 first frame applied", clk_en, 0);

        // bits 14/15 ignored
        run_and_check(16'h0000, 0);
        run_and_check(16'hC000, 0);
        chk(clk_en == 10'h3FF, "R6 upper bits ignored", clk_en, 10'h3FF);

        // sweep: slot byte exhaustive, device/feedback bits varied
        for (int i = 0; i < 256; i++) begin
            run_and_check({i[7:0] ^ 8'hA5, i[7:0]}, 0);
        end

        // start while busy is ignored
        run_and_check(16'h1234, 20);
        run_and_check(16'h2A55, 50);

        // start in the done cycle
        @(negedge clk);
        pat_ext = 16'h00F0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(clk_en, 0, cyc, held, bok);
        pat_ext = 16'h3F0F;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(clk_en == exp_en(16'h00F0), "R10 first mask applied", clk_en, exp_en(16'h00F0));
        chk(busy, "R10 busy stays high", busy, 1);
        wait_done(exp_en(16'h00F0), 0, cyc, held, bok);
        chk(cyc == 69, "R10 restart length", cyc, 69);
        chk(held && bok, "R10 held and busy during restart", {held, bok}, 2'b11);
        @(negedge clk);
        chk(clk_en == exp_en(16'h3F0F), "R10 second mask applied", clk_en, exp_en(16'h3F0F));

        summary();
    end

endmodule